// File: doc/BRIEF.md
# Dual-Bank Cache Request Scheduler

This block sits in front of a banked cache array and decides, every cycle, which of two incoming lookup requests may start a RAM access. The address selects a tag bank from one bit and, inside that tag bank, one of four data banks from two further bits. Two requests aimed at different tag banks can start together. Two requests aimed at the same tag bank are ordered by a fixed rule: port 0 always goes first. A data bank stays occupied for a number of cycles set by a static wait-state input, so slow RAMs can be modelled without changing the logic. Accesses to different data banks can start in consecutive cycles.

Each request carries an ID. Every tag bank has its own completion channel, and that channel returns the ID when the access finishes. Completions from the two tag banks are independent of each other, so results can return in a different order from the one in which requests were issued. Tag compare, replacement and the external bus are handled elsewhere.

Top module: `bank_sched`

## Requirements
- R1: The tag bank is given by address bit 6 (0 selects bank 0, 1 selects bank 1). The data bank is given by address bits 5:4, with values 0 to 3. A completion appears on the channel of the tag bank the request addressed: bit b of `cpl_valid_o`, and the ID in `cpl_id_o[b*4 +: 4]`.
- R2: If both ports present valid requests to different tag banks and both target data banks are free, both ready outputs are high in the same cycle and both requests are accepted.
- R3: If both ports present valid requests to the same tag bank, `req0_ready_o` depends only on whether its own data bank is free, and `req1_ready_o` is low. Port 1 is therefore stalled until port 0 leaves that tag bank.
- R4: A request accepted in cycle t raises its tag bank's completion valid in cycle t+1+W and carries the request's ID, where W is `wait_i`. The completion valid is high for exactly that one cycle.
- R5: A data bank is occupied for 1+W cycles, counting the acceptance cycle. During that time a request to the same data bank sees its ready low on either port. Ready goes high in cycle t+1+W.
- R6: Requests to different data banks of one tag bank, issued in consecutive cycles, are each accepted without a stall for any W. Their completions return in issue order, in consecutive cycles.
- R7: With W=0 a data bank is never occupied beyond its acceptance cycle. The same data bank can therefore accept one request every cycle.
- R8: While reset is held and right after it, no completion is signalled. All data banks are free, so a lone request on either port sees ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wait_i | input | 2 | Static RAM wait-state count W |
| req0_valid_i | input | 1 | Port 0 request valid |
| req0_addr_i | input | 32 | Port 0 physical address |
| req0_id_i | input | 4 | Port 0 request ID |
| req0_ready_o | output | 1 | Port 0 request accepted this cycle when valid |
| req1_valid_i | input | 1 | Port 1 request valid |
| req1_addr_i | input | 32 | Port 1 physical address |
| req1_id_i | input | 4 | Port 1 request ID |
| req1_ready_o | output | 1 | Port 1 request accepted this cycle when valid |
| cpl_valid_o | output | 2 | Completion valid, one bit per tag bank |
| cpl_id_o | output | 8 | Completion ID, 4 bits per tag bank |

## Verification
The bench uses the default parameters: 32-bit addresses, 4-bit IDs and a 2-bit wait-state input, with the tag bit at 6 and the data-bank field at bits 5:4. Because the wait input is 2 bits wide, every latency from single-cycle (W=0) up to four-cycle (W=3) can be reached. The bench sets W to each value it needs between scenarios, while the block is idle. The 4-bit IDs give every request in a scenario a distinct ID, so an ID that lands on the wrong channel or in the wrong cycle can be detected.

// File: rtl/bank_sched_pkg.sv
package bank_sched_pkg;
  localparam int unsigned DB_W   = 2;
  localparam int unsigned TB_N   = 2;
  localparam int unsigned DB_N   = 1 << DB_W;
  localparam int unsigned SLOT_N = TB_N * DB_N;

  // slot index = {tag bank, data bank}
  typedef logic [DB_W:0] slot_t;

  typedef struct packed {
    logic  vld;
    slot_t slot;
  } dec_t;
endpackage

// File: rtl/bank_sched_decode.sv
module bank_sched_decode
  import bank_sched_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned TB_BIT = 6,
  parameter int unsigned DB_LSB = 4
) (
  input  logic          valid_i,
  input  logic [AW-1:0] addr_i,
  output dec_t          dec_o
);
  assign dec_o.vld  = valid_i;
  assign dec_o.slot = {addr_i[TB_BIT], addr_i[DB_LSB +: DB_W]};
endmodule

// File: rtl/bank_sched_arb.sv
module bank_sched_arb
  import bank_sched_pkg::*;
(
  input  dec_t              d0_i,
  input  dec_t              d1_i,
  input  logic [SLOT_N-1:0] free_i,
  output logic              rdy0_o,
  output logic              rdy1_o,
  output logic [SLOT_N-1:0] load_o,
  output logic [SLOT_N-1:0] sel1_o
);
  logic tb_clash;

  // port 0 owns the tag bank whenever it is requesting it
  assign tb_clash = d0_i.vld && (d0_i.slot[DB_W] == d1_i.slot[DB_W]);
  assign rdy0_o   = free_i[d0_i.slot];
  assign rdy1_o   = free_i[d1_i.slot] && !tb_clash;

  always_comb begin
    for (int s = 0; s < SLOT_N; s++) begin
      logic hit0, hit1;
      hit0      = d0_i.vld && rdy0_o && (d0_i.slot == slot_t'(s));
      hit1      = d1_i.vld && rdy1_o && (d1_i.slot == slot_t'(s));
      load_o[s] = hit0 || hit1;
      sel1_o[s] = hit1;
    end
  end
endmodule

// File: rtl/bank_sched_slot.sv
module bank_sched_slot #(
  parameter int unsigned IW = 4,
  parameter int unsigned WW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [WW-1:0] wait_i,
  input  logic          load_i,
  input  logic [IW-1:0] id_i,
  output logic          free_o,
  output logic          done_o,
  output logic [IW-1:0] id_o
);
  logic [WW-1:0] cnt_q;
  logic          pend_q;
  logic [IW-1:0] id_q;

  assign free_o = (cnt_q == '0);
  assign done_o = pend_q && free_o;
  assign id_o   = id_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      id_q   <= '0;
    end else if (load_i) begin
      cnt_q  <= wait_i;
      pend_q <= 1'b1;
      id_q   <= id_i;
    end else begin
      if (!free_o) cnt_q <= cnt_q - 1'b1;
      if (done_o)  pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bank_sched.sv
module bank_sched
  import bank_sched_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned IW     = 4,
  parameter int unsigned WW     = 2,
  parameter int unsigned TB_BIT = 6,
  parameter int unsigned DB_LSB = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WW-1:0]    wait_i,
  input  logic             req0_valid_i,
  input  logic [AW-1:0]    req0_addr_i,
  input  logic [IW-1:0]    req0_id_i,
  output logic             req0_ready_o,
  input  logic             req1_valid_i,
  input  logic [AW-1:0]    req1_addr_i,
  input  logic [IW-1:0]    req1_id_i,
  output logic             req1_ready_o,
  output logic [TB_N-1:0]  cpl_valid_o,
  output logic [TB_N*IW-1:0] cpl_id_o
);
  dec_t              dec0, dec1;
  logic [SLOT_N-1:0] free, load, sel1, done;
  logic [IW-1:0]     slot_id [SLOT_N];

  bank_sched_decode #(.AW(AW), .TB_BIT(TB_BIT), .DB_LSB(DB_LSB)) u_dec0 (
    .valid_i(req0_valid_i), .addr_i(req0_addr_i), .dec_o(dec0)
  );
  bank_sched_decode #(.AW(AW), .TB_BIT(TB_BIT), .DB_LSB(DB_LSB)) u_dec1 (
    .valid_i(req1_valid_i), .addr_i(req1_addr_i), .dec_o(dec1)
  );

  bank_sched_arb u_arb (
    .d0_i(dec0), .d1_i(dec1), .free_i(free),
    .rdy0_o(req0_ready_o), .rdy1_o(req1_ready_o),
    .load_o(load), .sel1_o(sel1)
  );

  for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
    bank_sched_slot #(.IW(IW), .WW(WW)) u_slot (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .wait_i(wait_i),
      .load_i(load[s]),
      .id_i  (sel1[s] ? req1_id_i : req0_id_i),
      .free_o(free[s]),
      .done_o(done[s]),
      .id_o  (slot_id[s])
    );
  end

  // one tag bank accepts at most once per cycle with a fixed latency,
  // so at most one of its slots completes in any cycle
  for (genvar b = 0; b < TB_N; b++) begin : g_cpl
    always_comb begin
      cpl_valid_o[b]         = 1'b0;
      cpl_id_o[b*IW +: IW]   = '0;
      for (int d = 0; d < DB_N; d++) begin
        if (done[b*DB_N + d]) begin
          cpl_valid_o[b]       = 1'b1;
          cpl_id_o[b*IW +: IW] = cpl_id_o[b*IW +: IW] | slot_id[b*DB_N + d];
        end
      end
    end
  end
endmodule

// File: rtl/bank_sched_chk.sv
module bank_sched_chk
  import bank_sched_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned WW     = 2,
  parameter int unsigned TB_BIT = 6,
  parameter int unsigned DB_LSB = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [WW-1:0]   wait_i,
  input logic            req0_valid_i,
  input logic [AW-1:0]   req0_addr_i,
  input logic            req0_ready_o,
  input logic            req1_valid_i,
  input logic [AW-1:0]   req1_addr_i,
  input logic            req1_ready_o,
  input logic [TB_N-1:0] cpl_valid_o
);
  localparam int unsigned HN = 1 << WW;

  logic fire0, fire1, same_tb;
  logic [HN-1:0] hist [TB_N];

  assign fire0   = req0_valid_i && req0_ready_o;
  assign fire1   = req1_valid_i && req1_ready_o;
  assign same_tb = req0_addr_i[TB_BIT] == req1_addr_i[TB_BIT];

  for (genvar b = 0; b < TB_N; b++) begin : g_hist
    logic acc;
    assign acc = (fire0 && req0_addr_i[TB_BIT] == b[0]) ||
                 (fire1 && req1_addr_i[TB_BIT] == b[0]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist[b] <= '0;
      else         hist[b] <= {hist[b][HN-2:0], acc};
    end
    // R1, R4: completion on the addressed tag bank exactly 1+W cycles on
    p_cpl_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cpl_valid_o[b] == hist[b][wait_i]);
  end

  p_port0_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req0_valid_i && req1_valid_i && same_tb) |-> !req1_ready_o);

  p_tb_exclusive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fire0 && fire1 && same_tb));

  p_busy_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fire0) && req0_valid_i && wait_i != '0 &&
     req0_addr_i[TB_BIT] == $past(req0_addr_i[TB_BIT]) &&
     req0_addr_i[DB_LSB +: DB_W] == $past(req0_addr_i[DB_LSB +: DB_W]))
    |-> !req0_ready_o);

  p_w0_stream_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_i == '0 && req0_valid_i) |-> req0_ready_o);
endmodule

bind bank_sched bank_sched_chk #(
  .AW(AW), .WW(WW), .TB_BIT(TB_BIT), .DB_LSB(DB_LSB)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wait_i(wait_i),
  .req0_valid_i(req0_valid_i), .req0_addr_i(req0_addr_i), .req0_ready_o(req0_ready_o),
  .req1_valid_i(req1_valid_i), .req1_addr_i(req1_addr_i), .req1_ready_o(req1_ready_o),
  .cpl_valid_o(cpl_valid_o)
);

// File: tb/bank_sched_tb.sv
`timescale 1ns/1ps
module bank_sched_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  wait_i = 2'd0;
  logic        req0_valid_i = 1'b0, req1_valid_i = 1'b0;
  logic [31:0] req0_addr_i = '0, req1_addr_i = '0;
  logic [3:0]  req0_id_i = '0, req1_id_i = '0;
  logic        req0_ready_o, req1_ready_o;
  logic [1:0]  cpl_valid_o;
  logic [7:0]  cpl_id_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  bank_sched dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wait_i(wait_i),
    .req0_valid_i(req0_valid_i), .req0_addr_i(req0_addr_i), .req0_id_i(req0_id_i),
    .req0_ready_o(req0_ready_o),
    .req1_valid_i(req1_valid_i), .req1_addr_i(req1_addr_i), .req1_id_i(req1_id_i),
    .req1_ready_o(req1_ready_o),
    .cpl_valid_o(cpl_valid_o), .cpl_id_o(cpl_id_o)
  );

  function automatic logic [31:0] mk(input int tb, input int db);
    return 32'h8000_0000 | (32'(tb) << 6) | (32'(db) << 4) | 32'h5;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // next cycle: inputs set after negedge, checks 1ns later
  task automatic cyc();
    @(negedge clk_i);
  endtask

  task automatic idle(input int n);
    req0_valid_i = 1'b0;
    req1_valid_i = 1'b0;
    repeat (n) cyc();
  endtask

  task automatic set_wait(input logic [1:0] w);
    idle(6);
    wait_i = w;
  endtask

  task automatic t_reset();
    #1;
    chk("R8 cpl in reset", cpl_valid_o, 2'b00);
    repeat (2) cyc();
    rst_ni = 1'b1;
    cyc();
    req0_valid_i = 1'b1; req0_addr_i = mk(1, 3);
    #1;
    chk("R8 cpl after reset", cpl_valid_o, 2'b00);
    chk("R8 ready0 after reset", req0_ready_o, 1'b1);
    req0_valid_i = 1'b0; req1_valid_i = 1'b1; req1_addr_i = mk(0, 2);
    #1;
    chk("R8 ready1 after reset", req1_ready_o, 1'b1);
    req1_valid_i = 1'b0;
  endtask

  task automatic t_decode();
    set_wait(2'd0);
    cyc();
    req0_valid_i = 1'b1; req0_addr_i = mk(1, 2); req0_id_i = 4'd5;
    cyc(); req0_valid_i = 1'b0; #1;
    chk("R1 tb1 valid", cpl_valid_o, 2'b10);
    chk("R1 tb1 id", cpl_id_o[7:4], 4'd5);
    req0_valid_i = 1'b1; req0_addr_i = mk(0, 1); req0_id_i = 4'd3;
    cyc(); req0_valid_i = 1'b0; #1;
    chk("R1 tb0 valid", cpl_valid_o, 2'b01);
    chk("R1 tb0 id", cpl_id_o[3:0], 4'd3);
    cyc(); #1;
    chk("R4 single pulse", cpl_valid_o, 2'b00);
  endtask

  task automatic t_parallel();
    set_wait(2'd1);
    cyc();
    req0_valid_i = 1'b1; req0_addr_i = mk(0, 2); req0_id_i = 4'd10;
    req1_valid_i = 1'b1; req1_addr_i = mk(1, 2); req1_id_i = 4'd11;
    #1;
    chk("R2 ready0", req0_ready_o, 1'b1);
    chk("R2 ready1", req1_ready_o, 1'b1);
    cyc(); req0_valid_i = 1'b0; req1_valid_i = 1'b0; #1;
    chk("R4 W=1 not yet", cpl_valid_o, 2'b00);
    cyc(); #1;
    chk("R2 both complete", cpl_valid_o, 2'b11);
    chk("R2 both ids", cpl_id_o, {4'd11, 4'd10});
  endtask

  task automatic t_conflict();
    set_wait(2'd0);
    cyc();
    req0_valid_i = 1'b1; req0_addr_i = mk(1, 0); req0_id_i = 4'd12;
    req1_valid_i = 1'b1; req1_addr_i = mk(1, 1); req1_id_i = 4'd13;
    #1;
    chk("R3 port0 wins", req0_ready_o, 1'b1);
    chk("R3 port1 stalled", req1_ready_o, 1'b0);
    cyc(); req0_valid_i = 1'b0; #1;
    chk("R3 port1 released", req1_ready_o, 1'b1);
    chk("R3 first cpl id", {cpl_valid_o, cpl_id_o[7:4]}, {2'b10, 4'd12});
    cyc(); req1_valid_i = 1'b0; #1;
    chk("R3 second cpl id", {cpl_valid_o, cpl_id_o[7:4]}, {2'b10, 4'd13});
  endtask

  task automatic t_latency();
    set_wait(2'd2);
    cyc();
    req0_valid_i = 1'b1; req0_addr_i = mk(0, 1); req0_id_i = 4'd9;
    cyc(); req0_valid_i = 1'b0; #1;
    chk("R4 W=2 t+1", cpl_valid_o, 2'b00);
    cyc(); #1;
    chk("R4 W=2 t+2", cpl_valid_o, 2'b00);
    cyc(); #1;
    chk("R4 W=2 t+3", {cpl_valid_o, cpl_id_o[3:0]}, {2'b01, 4'd9});
    cyc(); #1;
    chk("R4 W=2 t+4", cpl_valid_o, 2'b00);
    set_wait(2'd3);
    cyc();
    req1_valid_i = 1'b1; req1_addr_i = mk(1, 3); req1_id_i = 4'd6;
    for (int k = 1; k <= 3; k++) begin
      cyc(); req1_valid_i = 1'b0; #1;
      chk("R4 W=3 early", cpl_valid_o, 2'b00);
    end
    cyc(); #1;
    chk("R4 W=3 t+4", {cpl_valid_o, cpl_id_o[7:4]}, {2'b10, 4'd6});
  endtask

  task automatic t_busy();
    set_wait(2'd2);
    cyc();
    req0_valid_i = 1'b1; req0_addr_i = mk(1, 3); req0_id_i = 4'd1;
    #1;
    chk("R5 first accept", req0_ready_o, 1'b1);
    cyc();
    req0_valid_i = 1'b0;
    req1_valid_i = 1'b1; req1_addr_i = mk(1, 3); req1_id_i = 4'd2;
    #1;
    chk("R5 busy t+1", req1_ready_o, 1'b0);
    req1_addr_i = mk(1, 1);
    #1;
    chk("R6 other bank free", req1_ready_o, 1'b1);
    req1_addr_i = mk(1, 3);
    cyc(); #1;
    chk("R5 busy t+2", req1_ready_o, 1'b0);
    cyc(); #1;
    chk("R5 free t+3", req1_ready_o, 1'b1);
    chk("R5 first cpl", {cpl_valid_o, cpl_id_o[7:4]}, {2'b10, 4'd1});
    cyc(); req1_valid_i = 1'b0;
    cyc(); cyc(); #1;
    chk("R5 second cpl", {cpl_valid_o, cpl_id_o[7:4]}, {2'b10, 4'd2});
  endtask

  task automatic t_stream();
    set_wait(2'd3);
    for (int k = 0; k < 4; k++) begin
      cyc();
      req0_valid_i = 1'b1; req0_addr_i = mk(0, k); req0_id_i = 4'(k + 4);
      #1;
      chk("R6 stream ready", req0_ready_o, 1'b1);
      chk("R6 no early cpl", cpl_valid_o, 2'b00);
    end
    for (int k = 0; k < 4; k++) begin
      cyc(); req0_valid_i = 1'b0; #1;
      chk("R6 in-order cpl", {cpl_valid_o, cpl_id_o[3:0]}, {2'b01, 4'(k + 4)});
    end
  endtask

  task automatic t_w0_same();
    set_wait(2'd0);
    for (int k = 1; k <= 3; k++) begin
      cyc();
      req1_valid_i = 1'b1; req1_addr_i = mk(1, 0); req1_id_i = 4'(k);
      #1;
      chk("R7 same bank ready", req1_ready_o, 1'b1);
      if (k > 1) chk("R7 per-cycle cpl", {cpl_valid_o, cpl_id_o[7:4]}, {2'b10, 4'(k - 1)});
    end
    cyc(); req1_valid_i = 1'b0; #1;
    chk("R7 last cpl", {cpl_valid_o, cpl_id_o[7:4]}, {2'b10, 4'd3});
  endtask

  initial begin
    t_reset();
    t_decode();
    t_parallel();
    t_conflict();
    t_latency();
    t_busy();
    t_stream();
    t_w0_same();
    idle(4);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule